// File: doc/BRIEF.md
# Four-Bank Bidirectional Serial-to-Parallel Driver Core

This block is the logic core of a 32-output display driver. Four 8-stage shift chains (banks A to D) share one clock. Each chain takes one bit from its own serial input on every rising edge, so the four banks fill four times faster than one chain would. A single direction input sets which way every chain moves. Each bank also has a serial output that feeds the next device in a cascade.

A capture register stage holds a snapshot of the chains. It reloads only while the latch-enable input is high, and the chains keep shifting whatever that input is set to. The captured pattern then passes through a registered output gate. That gate applies, in this order of priority, a device-wide chip-select force, per-bank blanking, and a final polarity inversion. The result is 32 parallel logic outputs that drive external level shifters.

Top module: `spd_core`

## Requirements
- R1: While `rst` is high at a rising edge, every chain stage, every capture bit and every bit of `dout` becomes 0 after that edge, and so does `sout`.
- R2: With `dir_fwd` = 1, at each edge stage 1 of bank b takes `sin[b]` and stage k+1 takes the old stage k (bank index b: 0 = A, 1 = B, 2 = C, 3 = D).
- R3: With `dir_fwd` = 0, at each edge stage 8 of bank b takes `sin[b]` and stage k takes the old stage k+1.
- R4: `sout[b]` shows stage 8 of bank b when `dir_fwd` = 1 and stage 1 when `dir_fwd` = 0, with no clock delay after a change of `dir_fwd`.
- R5: On an edge with `le` = 1, the capture bits load the chain contents as they were just before that edge. With `le` = 0 they hold. The chains shift in both cases.
- R6: When `cs_n` = 0 before an edge, every bit of `dout` after that edge equals the inverse of `pol`. This overrides both data and blanking.
- R7: When `cs_n` = 1 and `blank_n[b]` = 0 before an edge, the 8 outputs of bank b after that edge equal the inverse of `pol`. The other banks still show their gated capture data.
- R8: When `cs_n` = 1 and `blank_n[b]` = 1, an output bit after the edge equals its capture bit if `pol` = 1, and the inverted capture bit if `pol` = 0.
- R9: `dout` is registered. Bit `dout[8*b + s - 1]` is bank b, stage s (s = 1..8). It reflects the capture bits and the `blank_n`, `cs_n` and `pol` values present just before the edge that loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for chains, capture and outputs |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | 1 = forward shift (serial in at stage 1), 0 = reverse (serial in at stage 8) |
| sin | input | 4 | Serial data, one bit per bank, bit 0 = bank A |
| le | input | 1 | Capture enable, 1 = load chains into capture bits |
| blank_n | input | 4 | Per-bank blank, active low, bit 0 = bank A |
| cs_n | input | 1 | Chip select, active low; low forces all outputs |
| pol | input | 1 | Polarity, 1 = true data, 0 = inverted |
| sout | output | 4 | Cascade output per bank, last stage in the shift direction |
| dout | output | 32 | Gated parallel outputs, bank-major, stage 1 lowest |

## Verification
Two things can happen on the same edge: the capture can load while the chains advance, and a chip-select force can coincide with a bank blank. The bench drives `le` high during active shifting in both directions. It then confirms that the captured pattern is the pre-edge chain rather than the shifted one. It also lowers `cs_n` and several `blank_n` bits together under both polarities. A behavioural reference model, stepped on every clock, judges each output cycle, so any wrong priority or off-by-one capture shows up as a mismatch on `dout` or `sout`.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic {
    SHIFT_REV = 1'b0,
    SHIFT_FWD = 1'b1
  } shift_dir_e;

  // chip select beats blanking, blanking beats data, polarity applied last
  function automatic logic gate_bit(input logic data,
                                    input logic bank_on,
                                    input logic sel_on,
                                    input logic pol_true);
    logic pre;
    pre = sel_on & bank_on & data;
    return pre ^ ~pol_true;
  endfunction

endpackage

// File: rtl/spd_shift_chain.sv
module spd_shift_chain
  import spd_pkg::*;
#(
  parameter int NSTAGE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_fwd,
  input  logic              sin,
  output logic [NSTAGE-1:0] chain_q,
  output logic              sout
);

  shift_dir_e dir;
  assign dir = shift_dir_e'(dir_fwd);

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (dir == SHIFT_FWD) begin
      chain_q <= {chain_q[NSTAGE-2:0], sin};
    end else begin
      chain_q <= {sin, chain_q[NSTAGE-1:1]};
    end
  end

  assign sout = (dir == SHIFT_FWD) ? chain_q[NSTAGE-1] : chain_q[0];

endmodule

// File: rtl/spd_latch_bank.sv
module spd_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (le) begin
      q <= d;
    end
  end

endmodule

// File: rtl/spd_out_gate.sv
module spd_out_gate
  import spd_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int NSTAGE = 8,
  localparam int NOUT  = NBANK * NSTAGE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOUT-1:0] latch_q,
  input  logic [NBANK-1:0] blank_n,
  input  logic            cs_n,
  input  logic            pol,
  output logic [NOUT-1:0] dout
);

  logic [NOUT-1:0] gated;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar s = 0; s < NSTAGE; s++) begin : g_bit
      assign gated[b*NSTAGE + s] =
        gate_bit(latch_q[b*NSTAGE + s], blank_n[b], cs_n, pol);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else begin
      dout <= gated;
    end
  end

endmodule

// File: rtl/spd_core.sv
module spd_core #(
  parameter int NBANK  = 4,
  parameter int NSTAGE = 8,
  localparam int NOUT  = NBANK * NSTAGE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_fwd,
  input  logic [NBANK-1:0] sin,
  input  logic             le,
  input  logic [NBANK-1:0] blank_n,
  input  logic             cs_n,
  input  logic             pol,
  output logic [NBANK-1:0] sout,
  output logic [NOUT-1:0]  dout
);

  logic [NOUT-1:0] chain_all;
  logic [NOUT-1:0] latch_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    spd_shift_chain #(.NSTAGE(NSTAGE)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .dir_fwd (dir_fwd),
      .sin     (sin[b]),
      .chain_q (chain_all[b*NSTAGE +: NSTAGE]),
      .sout    (sout[b])
    );

    spd_latch_bank #(.WIDTH(NSTAGE)) u_latch (
      .clk (clk),
      .rst (rst),
      .le  (le),
      .d   (chain_all[b*NSTAGE +: NSTAGE]),
      .q   (latch_all[b*NSTAGE +: NSTAGE])
    );
  end

  spd_out_gate #(.NBANK(NBANK), .NSTAGE(NSTAGE)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .latch_q (latch_all),
    .blank_n (blank_n),
    .cs_n    (cs_n),
    .pol     (pol),
    .dout    (dout)
  );

endmodule

// File: rtl/spd_core_chk.sv
module spd_core_chk #(
  parameter int NBANK  = 4,
  parameter int NSTAGE = 8,
  localparam int NOUT  = NBANK * NSTAGE
) (
  input logic             clk,
  input logic             rst,
  input logic             dir_fwd,
  input logic [NBANK-1:0] sin,
  input logic             le,
  input logic [NBANK-1:0] blank_n,
  input logic             cs_n,
  input logic             pol,
  input logic [NBANK-1:0] sout,
  input logic [NOUT-1:0]  dout,
  input logic [NOUT-1:0]  chain,
  input logic [NOUT-1:0]  latch
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dout == '0 && latch == '0 && chain == '0 && sout == '0)); // R1

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(latch)); // R5

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    le |=> latch == $past(chain)); // R5

  AST_CS_FORCE: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> dout == {NOUT{~$past(pol)}}); // R6

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (rst)
      dir_fwd |=> (chain[b*NSTAGE+1 +: NSTAGE-1] == $past(chain[b*NSTAGE +: NSTAGE-1])
                   && chain[b*NSTAGE] == $past(sin[b]))); // R2

    AST_REV_SHIFT: assert property (@(posedge clk) disable iff (rst)
      !dir_fwd |=> (chain[b*NSTAGE +: NSTAGE-1] == $past(chain[b*NSTAGE+1 +: NSTAGE-1])
                    && chain[b*NSTAGE+NSTAGE-1] == $past(sin[b]))); // R3

    AST_BANK_BLANK: assert property (@(posedge clk) disable iff (rst)
      (cs_n && !blank_n[b]) |=> dout[b*NSTAGE +: NSTAGE] == {NSTAGE{~$past(pol)}}); // R7
  end

endmodule

bind spd_core spd_core_chk #(.NBANK(NBANK), .NSTAGE(NSTAGE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .dir_fwd (dir_fwd),
  .sin     (sin),
  .le      (le),
  .blank_n (blank_n),
  .cs_n    (cs_n),
  .pol     (pol),
  .sout    (sout),
  .dout    (dout),
  .chain   (chain_all),
  .latch   (latch_all)
);

// File: tb/sim_spd_core.sv
module sim_spd_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dir_fwd = 1'b1;
  logic [3:0]  sin = '0;
  logic        le = 1'b0;
  logic [3:0]  blank_n = 4'hF;
  logic        cs_n = 1'b1;
  logic        pol = 1'b1;
  logic [3:0]  sout;
  logic [31:0] dout;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  bit mch [4][8];
  bit mlat[4][8];
  bit mout[32];

  always #2 clk = ~clk;

  spd_core u0 (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .sin(sin), .le(le),
    .blank_n(blank_n), .cs_n(cs_n), .pol(pol), .sout(sout), .dout(dout)
  );

  task automatic model_edge();
    bit nch[4][8];
    if (rst) begin
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 8; s++) begin
          mch[b][s] = 0; mlat[b][s] = 0; mout[b*8+s] = 0;
        end
      return;
    end
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 8; s++) begin
        bit v;
        v = (cs_n && blank_n[b]) ? mlat[b][s] : 1'b0;
        mout[b*8+s] = pol ? v : !v;
      end
    if (le)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 8; s++) mlat[b][s] = mch[b][s];
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 8; s++) begin
        if (dir_fwd) nch[b][s] = (s == 0) ? sin[b] : mch[b][s-1];
        else         nch[b][s] = (s == 7) ? sin[b] : mch[b][s+1];
      end
      for (int s = 0; s < 8; s++) mch[b][s] = nch[b][s];
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] ed;
    logic [3:0]  es;
    for (int i = 0; i < 32; i++) ed[i] = mout[i];
    for (int b = 0; b < 4; b++) es[b] = dir_fwd ? mch[b][7] : mch[b][0];
    n_checks++;
    if (dout !== ed) begin
      n_fail++;
      $display("FAIL %s dout actual=%h expected=%h", tag, dout, ed);
    end
    n_checks++;
    if (sout !== es) begin
      n_fail++;
      $display("FAIL %s sout actual=%h expected=%h", tag, sout, es);
    end
  endtask

  // inputs set at a falling edge, model stepped at the rising edge, checked at the next falling edge
  task automatic step(input logic r, input logic d, input logic [3:0] s,
                      input logic l, input logic [3:0] bn, input logic c,
                      input logic p, input string tag);
    rst = r; dir_fwd = d; sin = s; le = l; blank_n = bn; cs_n = c; pol = p;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 1, 4'hF, 1, 4'hF, 1, 1, "R1");
    step(1, 1, 4'hF, 1, 4'hF, 1, 1, "R1");
    // forward fill with latch held: outputs stay zero
    for (int i = 0; i < 8; i++)
      step(0, 1, 4'(i * 5 + 3), 0, 4'hF, 1, 1, "R2 R4 R5");
    step(0, 1, 4'hA, 1, 4'hF, 1, 1, "R5 capture during forward shift");
    for (int i = 0; i < 3; i++)
      step(0, 1, 4'h5, 0, 4'hF, 1, 1, "R9 R8 true polarity");
    // reverse direction, sout switches to stage 1
    for (int i = 0; i < 8; i++)
      step(0, 0, 4'(i * 7 + 1), 0, 4'hF, 1, 1, "R3 R4");
    step(0, 0, 4'h3, 1, 4'hF, 1, 1, "R5 capture during reverse shift");
    step(0, 0, 4'h0, 0, 4'hF, 1, 0, "R8 inverted");
    step(0, 0, 4'h0, 0, 4'hF, 1, 0, "R8 inverted");
    step(0, 1, 4'h0, 0, 4'b1101, 1, 1, "R7 bank B blank");
    step(0, 1, 4'h0, 0, 4'b1101, 1, 1, "R7 bank B blank");
    step(0, 1, 4'h0, 0, 4'b0110, 1, 0, "R7 blank inverted");
    step(0, 1, 4'h0, 0, 4'b0110, 1, 0, "R7 blank inverted");
    step(0, 1, 4'hF, 0, 4'b0101, 0, 1, "R6 cs with blank");
    step(0, 1, 4'hF, 0, 4'b0101, 0, 0, "R6 cs with blank inverted");
    step(0, 0, 4'hF, 1, 4'hF, 0, 0, "R6 cs during capture");
    // mixed stimulus
    for (int i = 0; i < 400; i++)
      step(0, 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom | ($urandom & 1)),
           1'(($urandom % 4) != 0), 1'($urandom), "R2 R3 R4 R5 R6 R7 R8 R9 mixed");
    step(1, 1, 4'hF, 1, 4'hF, 1, 0, "R1 mid-run reset");
    step(0, 1, 4'hF, 0, 4'hF, 1, 0, "R1 after reset");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule